// File: doc/BRIEF.md
# Half-Bridge Protection and Fault Supervisor

This block sits between the serial command path and the gate drivers of six half-bridges. Each half-bridge has one low-side and one high-side switch. It holds the last committed control word and turns the per-switch requests in that word into gated switch enables. Faults can remove those enables. Each switch can be shut off by its own overcurrent timer. Every switch is shut off by a supply undervoltage timer, by over-temperature, or by inhibit. The block also builds the status word that is shifted back to the host.

Fault detection in the analog domain is outside the block. The comparators arrive as plain digital levels, and all delays count pulses of a slow time-base enable `tick` (nominally about 45 kHz). Control words arrive through a valid/ready port. `cmd_ready` is held high, so there is never back-pressure, and a word offered with `cmd_valid` high is taken on that clock edge. The stored control bits govern the outputs from the next cycle. A clear request is carried in bit 0 of the word and acts on the edge where the word is accepted. Status and enables are combinational views of the latched state and the live fault inputs.

Top module: `hb_prot_sup`

## Requirements
- R1: Control word layout, for NCH = 6. Bit 0 requests a clear. Bit 2c+1 requests the low-side switch of channel c and bit 2c+2 its high-side switch (c = 0..5). Bit 13 low enables the open-load test. Bit 14 high selects the long short-circuit delay. Bit 15 high means run. After reset the stored word has bits 15, 14 and 13 high and all other bits low, so all switches are off, `status` shows bit 14 = NOT inh_n, and its other bits are low apart from bit 0.
- R2: `drv_en[2c]` is the low-side enable and `drv_en[2c+1]` the high-side enable of channel c. A channel whose two requests are both high drives both enables low, and the two enables of a channel are never high together.
- R3: A requested switch whose overcurrent input stays high for SC_FAST_TICKS consecutive ticks is turned off on the last of those ticks. The count is SC_SLOW_TICKS when bit 14 is high. Only that switch turns off, and status bit 13 is set. The count restarts from zero whenever the overcurrent input drops or the switch is no longer requested.
- R4: An accepted word with bit 0 high clears status bit 13, status bit 15 and the thermal latch, and it re-enables switches that were shut off by overcurrent. If an overcurrent or undervoltage that has already expired is still present, its latch is set again on the next tick.
- R5: Undervoltage held for UV_TICKS consecutive ticks sets status bit 15 and drives every enable low. The enables return in the cycle after the undervoltage input drops. Bit 15 stays high until a clear.
- R6: While the shutdown-temperature input is high, and from then on until a clear is accepted while that input is low, every enable is low and `status` reads all ones. A clear offered while the input is high has no effect.
- R7: Status bit 0 equals `temp_warn` in the same cycle and is not latched, except when R6 forces all ones.
- R8: When bit 15 of the stored word is low or `inh_n` is low, every enable is low and status bit 14 is high. New words are still accepted while inhibited.
- R9: Status bit i+1 shows `drv_en[i]`. The exception is when the open-load test is enabled (bit 13 low) and switch i is not requested: bit i+1 then shows `open_load[i]`.
- R10: `cmd_ready` is always high, and a word accepted on one edge governs the enables from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| cmd_valid | input | 1 | Control word offered |
| cmd_ready | output | 1 | Always high; control word accepted |
| cmd_word | input | 2*NCH+4 | Control word (layout in R1) |
| oc_flag | input | 2*NCH | Per-switch overcurrent compare |
| uv_flag | input | 1 | Supply undervoltage compare |
| temp_warn | input | 1 | Temperature above warning level |
| temp_shut | input | 1 | Temperature above shutdown level |
| open_load | input | 2*NCH | Per-switch open-load compare |
| inh_n | input | 1 | External inhibit pin, low inhibits |
| drv_en | output | 2*NCH | Gated switch enables |
| status | output | 2*NCH+4 | Status word (layout in R6 to R9) |

## Verification
The bench builds the block with SC_FAST_TICKS = 3, SC_SLOW_TICKS = 6 and UV_TICKS = 5. With these values every delay expiry, the restart of an interrupted count, and the re-latch after a clear while a fault is still present happen within a handful of ticks. Random stimulus can therefore hit them often, together with colliding clears, inhibit and thermal events. The default counts of tens to hundreds of ticks would make these cases rare.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef struct packed {
    logic ot;       // thermal latch
    logic inhibit;  // software or pin inhibit
    logic sc_lat;   // short-circuit latch
    logic uv_lat;   // supply-fail latch
  } hb_flags_t;

  // ones at the low-side positions (even indices)
  function automatic logic [63:0] ls_mask(input int nsw);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < nsw; i += 2) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/hb_delay_timer.sv
module hb_delay_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cond,
  input  logic [CW-1:0] lim,
  output logic          fire
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt >= lim - CW'(1));
  assign fire   = cond & tick & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!cond)  cnt <= '0;
    else if (tick)   cnt <= at_end ? lim : cnt + CW'(1);
  end

  AST_CNT_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && !tick) |=> (cnt == $past(cnt) || cnt == '0)); // R3

endmodule

// File: rtl/hb_status_enc.sv
module hb_status_enc
  import hb_pkg::*;
#(
  parameter int NSW = 12
) (
  input  logic [NSW-1:0] cmd_sw,
  input  logic           olt_en,
  input  logic [NSW-1:0] drv_en,
  input  logic [NSW-1:0] open_load,
  input  logic           warn,
  input  hb_flags_t      flags,
  output logic [NSW+3:0] status
);
  always_comb begin
    if (flags.ot) begin
      status = '1;
    end else begin
      status[0] = warn;
      for (int i = 0; i < NSW; i++)
        status[i+1] = (olt_en && !cmd_sw[i]) ? open_load[i] : drv_en[i];
      status[NSW+1] = flags.sc_lat;
      status[NSW+2] = flags.inhibit;
      status[NSW+3] = flags.uv_lat;
    end
  end
endmodule

// File: rtl/hb_prot_sup.sv
module hb_prot_sup
  import hb_pkg::*;
#(
  parameter int NCH           = 6,
  parameter int SC_FAST_TICKS = 68,
  parameter int SC_SLOW_TICKS = 540,
  parameter int UV_TICKS      = 630
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2*NCH+3:0]   cmd_word,
  input  logic [2*NCH-1:0]   oc_flag,
  input  logic               uv_flag,
  input  logic               temp_warn,
  input  logic               temp_shut,
  input  logic [2*NCH-1:0]   open_load,
  input  logic               inh_n,
  output logic [2*NCH-1:0]   drv_en,
  output logic [2*NCH+3:0]   status
);
  localparam int NSW    = 2 * NCH;
  localparam int CWW    = NSW + 4;
  localparam int B_OLT  = NSW + 1;
  localparam int B_SLOW = NSW + 2;
  localparam int B_RUN  = NSW + 3;
  localparam int SC_MAX = (SC_SLOW_TICKS > SC_FAST_TICKS) ? SC_SLOW_TICKS : SC_FAST_TICKS;
  localparam int SC_CW  = $clog2(SC_MAX + 1);
  localparam int UV_CW  = $clog2(UV_TICKS + 1);
  localparam logic [NSW-1:0] LS_MASK = NSW'(ls_mask(NSW));
  localparam logic [CWW-1:1] CMD_RST = {3'b111, {(NSW){1'b0}}};

  logic [CWW-1:1] cmd_q;
  logic           clr;
  logic [NSW-1:0] cmd_sw, guard, sc_fire, sc_off;
  logic           inhibit, sc_lat, uv_lat, uv_off, ot_lat, uv_fire, all_ok;
  logic [SC_CW-1:0] sc_lim;
  hb_flags_t      flags;

  assign cmd_ready = 1'b1;
  assign clr       = cmd_valid & cmd_word[0];

  always_ff @(posedge clk) begin
    if (!rst_n)         cmd_q <= CMD_RST;
    else if (cmd_valid) cmd_q <= cmd_word[CWW-1:1];
  end

  assign cmd_sw  = cmd_q[NSW:1];
  assign inhibit = ~cmd_q[B_RUN] | ~inh_n;
  assign sc_lim  = cmd_q[B_SLOW] ? SC_CW'(SC_SLOW_TICKS) : SC_CW'(SC_FAST_TICKS);

  // cross-conduction guard per channel
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign guard[2*c]   = cmd_sw[2*c]   & ~cmd_sw[2*c+1];
    assign guard[2*c+1] = cmd_sw[2*c+1] & ~cmd_sw[2*c];
  end

  for (genvar i = 0; i < NSW; i++) begin : g_sc
    hb_delay_timer #(.CW(SC_CW)) u_sc_tmr (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .cond (oc_flag[i] & guard[i]), .lim (sc_lim), .fire (sc_fire[i])
    );
  end

  hb_delay_timer #(.CW(UV_CW)) u_uv_tmr (
    .clk (clk), .rst_n (rst_n), .tick (tick),
    .cond (uv_flag), .lim (UV_CW'(UV_TICKS)), .fire (uv_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_off <= '0;
      sc_lat <= 1'b0;
      uv_lat <= 1'b0;
      uv_off <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      sc_off <= sc_fire | (clr ? '0 : sc_off);
      sc_lat <= (|sc_fire) | (sc_lat & ~clr);
      uv_lat <= uv_fire | (uv_lat & ~clr);
      uv_off <= uv_flag & (uv_fire | uv_off);
      ot_lat <= temp_shut | (ot_lat & ~clr);
    end
  end

  assign all_ok = ~inhibit & ~uv_off & ~ot_lat;
  assign drv_en = guard & ~sc_off & {NSW{all_ok}};

  assign flags = '{ot: ot_lat, inhibit: inhibit, sc_lat: sc_lat, uv_lat: uv_lat};

  hb_status_enc #(.NSW(NSW)) u_stat (
    .cmd_sw (cmd_sw), .olt_en (~cmd_q[B_OLT]), .drv_en (drv_en),
    .open_load (open_load), .warn (temp_warn), .flags (flags), .status (status)
  );

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & (drv_en >> 1) & LS_MASK) == '0); // R2
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> drv_en == '0); // R8
  AST_OT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(temp_shut)) |-> (status == '1 && drv_en == '0)); // R6
  AST_SC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !sc_lat); // R4
  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lat && !clr) |=> uv_lat); // R5

endmodule

// File: tb/test_hb_prot_sup.sv
module test_hb_prot_sup;
  localparam int FAST = 3, SLOW = 6, UVT = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [11:0] oc = '0, ol = '0;
  logic uv = 1'b0, tw = 1'b0, ts = 1'b0, inh_n = 1'b1;
  logic cmd_ready;
  logic [11:0] drv_en;
  logic [15:0] status;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_cmd;
  int          m_sc_cnt [12];
  int          m_uv_cnt;
  logic [11:0] m_sc_off;
  logic        m_sc_lat, m_uv_lat, m_uv_off, m_ot;

  always #2 clk = ~clk;

  hb_prot_sup #(.NCH(6), .SC_FAST_TICKS(FAST), .SC_SLOW_TICKS(SLOW), .UV_TICKS(UVT)) i_hb_prot_sup (
    .clk (clk), .rst_n (rst_n), .tick (tick), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_word (cmd_word), .oc_flag (oc), .uv_flag (uv), .temp_warn (tw), .temp_shut (ts),
    .open_load (ol), .inh_n (inh_n), .drv_en (drv_en), .status (status)
  );

  function automatic logic [11:0] guard_of(input logic [15:0] c);
    logic [11:0] g;
    for (int ch = 0; ch < 6; ch++) begin
      g[2*ch]   = c[2*ch+1] & ~c[2*ch+2];
      g[2*ch+1] = c[2*ch+2] & ~c[2*ch+1];
    end
    return g;
  endfunction

  function automatic logic [11:0] exp_drv();
    logic ok;
    ok = m_cmd[15] & inh_n & ~m_uv_off & ~m_ot;
    return guard_of(m_cmd) & ~m_sc_off & {12{ok}};
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    logic [11:0] d;
    if (m_ot) return 16'hFFFF;
    d = exp_drv();
    s[0] = tw;
    for (int i = 0; i < 12; i++)
      s[i+1] = (!m_cmd[13] && !m_cmd[i+1]) ? ol[i] : d[i];
    s[13] = m_sc_lat;
    s[14] = ~m_cmd[15] | ~inh_n;
    s[15] = m_uv_lat;
    return s;
  endfunction

  task automatic model_reset();
    m_cmd = 16'hE000;
    for (int i = 0; i < 12; i++) m_sc_cnt[i] = 0;
    m_uv_cnt = 0; m_sc_off = '0;
    m_sc_lat = 0; m_uv_lat = 0; m_uv_off = 0; m_ot = 0;
  endtask

  task automatic model_step();
    logic clr, uvf;
    logic [11:0] g, fire;
    int lim;
    clr = cmd_valid & cmd_word[0];
    lim = m_cmd[14] ? SLOW : FAST;
    g = guard_of(m_cmd);
    fire = '0; uvf = 0;
    for (int i = 0; i < 12; i++) begin
      if (!(oc[i] && g[i])) m_sc_cnt[i] = 0;
      else if (tick) begin
        if (m_sc_cnt[i] >= lim - 1) begin fire[i] = 1; m_sc_cnt[i] = lim; end
        else m_sc_cnt[i]++;
      end
    end
    if (!uv) m_uv_cnt = 0;
    else if (tick) begin
      if (m_uv_cnt >= UVT - 1) begin uvf = 1; m_uv_cnt = UVT; end
      else m_uv_cnt++;
    end
    m_sc_off = fire | (clr ? 12'h000 : m_sc_off);
    m_sc_lat = (|fire) | (m_sc_lat & ~clr);
    m_uv_lat = uvf | (m_uv_lat & ~clr);
    m_uv_off = uv & (uvf | m_uv_off);
    m_ot     = ts | (m_ot & ~clr);
    if (cmd_valid) m_cmd = {cmd_word[15:1], 1'b0};
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // called at a negedge with inputs set; samples 1 ns later, well before the posedge
  task automatic step(input string tag);
    #1;
    chk({tag, " drv_en"}, {4'h0, drv_en}, {4'h0, exp_drv()});
    chk({tag, " status"}, status, exp_status());
    chk("R10 cmd_ready", {15'h0, cmd_ready}, 16'h0001);
    model_step();
    @(negedge clk);
  endtask

  task automatic cmd(input string tag, input logic [15:0] w);
    cmd_valid = 1'b1; cmd_word = w; step(tag);
    cmd_valid = 1'b0; step(tag);
  endtask

  task automatic tk(input string tag);
    tick = 1'b1; step(tag);
    tick = 1'b0; step(tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    chk("R1 reset status", status, 16'h0000);
    chk("R1 reset drv_en", {4'h0, drv_en}, 16'h0000);

    // R2: both requests of channel 0 -> both off; LS1+LS2 -> 0x005
    cmd("R2", 16'hA006);
    chk("R2 both on", {4'h0, drv_en}, 16'h0000);
    cmd("R2", 16'hA00A);
    chk("R2 two lows", {4'h0, drv_en}, 16'h0005);

    // R3 fast delay on switch 0
    oc = 12'h001;
    tk("R3"); tk("R3");
    chk("R3 before expiry", {4'h0, drv_en}, 16'h0005);
    tk("R3");
    chk("R3 only switch 0 off", {4'h0, drv_en}, 16'h0004);
    chk("R3 sc bit", {15'h0, status[13]}, 16'h0001);

    // R4 clear with fault still present, then re-latch on next tick
    cmd("R4", 16'hA00B);
    chk("R4 re-enabled", {4'h0, drv_en}, 16'h0005);
    chk("R4 sc cleared", {15'h0, status[13]}, 16'h0000);
    tk("R4");
    chk("R4 re-latched", {4'h0, drv_en}, 16'h0004);
    oc = 12'h000;
    cmd("R4", 16'hE00B);

    // R3 slow delay, and restart on a dropped input
    oc = 12'h001;
    repeat (5) tk("R3");
    chk("R3 slow not yet", {4'h0, drv_en}, 16'h0005);
    oc = 12'h000; step("R3"); oc = 12'h001;
    repeat (5) tk("R3");
    chk("R3 restart", {4'h0, drv_en}, 16'h0005);
    tk("R3");
    chk("R3 slow expiry", {4'h0, drv_en}, 16'h0004);
    oc = 12'h000;
    cmd("R4", 16'hA00B);

    // R5 undervoltage
    uv = 1'b1;
    repeat (4) tk("R5");
    chk("R5 before expiry", {4'h0, drv_en}, 16'h0005);
    tk("R5");
    chk("R5 all off", {4'h0, drv_en}, 16'h0000);
    chk("R5 flag", {15'h0, status[15]}, 16'h0001);
    uv = 1'b0; step("R5");
    chk("R5 outputs back", {4'h0, drv_en}, 16'h0005);
    chk("R5 flag held", {15'h0, status[15]}, 16'h0001);
    cmd("R4", 16'hA00B);
    chk("R4 uv cleared", {15'h0, status[15]}, 16'h0000);

    // R6 thermal shutdown
    ts = 1'b1; step("R6");
    chk("R6 all ones", status, 16'hFFFF);
    cmd("R6", 16'hA00B);
    chk("R6 clear while hot", status, 16'hFFFF);
    ts = 1'b0; step("R6");
    chk("R6 cooled still latched", {4'h0, drv_en}, 16'h0000);
    cmd("R6", 16'hA00B);
    chk("R6 recovered", {4'h0, drv_en}, 16'h0005);

    // R7 warning pass-through
    tw = 1'b1; step("R7");
    chk("R7 warn high", {15'h0, status[0]}, 16'h0001);
    tw = 1'b0; step("R7");
    chk("R7 warn low", {15'h0, status[0]}, 16'h0000);

    // R8 inhibit by pin and by run bit
    inh_n = 1'b0; step("R8");
    chk("R8 pin inhibit", {4'h0, drv_en}, 16'h0000);
    chk("R8 inh bit", {15'h0, status[14]}, 16'h0001);
    cmd("R8", 16'hA008);
    inh_n = 1'b1; step("R8");
    chk("R8 word taken while inhibited", {4'h0, drv_en}, 16'h0004);
    cmd("R8", 16'h2008);
    chk("R8 run bit low", {4'h0, drv_en}, 16'h0000);

    // R9 open-load reporting
    cmd("R9", 16'h8008);
    ol = 12'hFFF; step("R9");
    chk("R9 open all", status, 16'h1FFE);
    ol = 12'h000; step("R9");
    chk("R9 open none", status, 16'h0008);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      tick      = ($urandom_range(0, 2) == 0);
      cmd_valid = ($urandom_range(0, 9) == 0);
      cmd_word  = 16'($urandom);
      cmd_word[0]  = ($urandom_range(0, 5) == 0);
      cmd_word[15] = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 19) == 0) oc = 12'($urandom);
      if ($urandom_range(0, 29) == 0) uv = ~uv;
      if ($urandom_range(0, 199) == 0) ts = ~ts;
      if ($urandom_range(0, 9) == 0) tw = ~tw;
      if ($urandom_range(0, 59) == 0) inh_n = ~inh_n;
      ol = 12'($urandom);
      step("R2 R9 random");
    end

    done = 1'b1;
    summary();
  end
endmodule